// File: doc/BRIEF.md
# Clock Source Change Sequencer

This block manages a run-time change of the system clock. There are four oscillators: fast RC, primary crystal, low-power crystal and low-power RC. The fast RC and the primary oscillator each have a second form that runs through a shared PLL. Software first writes a key pair to open one byte of a 16-bit control/status word for a single cycle. It then writes the requested source code and sets a start bit. The block checks the request and takes one of three actions. It drops the request if it is redundant. It refuses the request if it is illegal. Otherwise it enables the target oscillator (and the PLL when the target needs it) and waits for the oscillator's ready indication and, if needed, PLL lock. It then lets ten rising edges of the target oscillator pass, measured in that oscillator's own domain. Only then does it move the clock-select output and release the old oscillator.

A configuration input decides whether run-time switching is allowed at all. When it is off, the reported source simply follows the power-up source input. Two other inputs keep oscillators alive after a change: a watchdog/monitor-enable input keeps the low-power RC running, and a keep bit in the control word keeps the low-power crystal running. The glitch-free clock multiplexer and the analog oscillators sit outside this block and are driven by its outputs.

Top module: `clksw_ctrl`

## Requirements
- R1: Source codes are 0 fast RC, 1 fast RC with PLL, 2 primary, 3 primary with PLL, 4 low-power crystal, 5 low-power RC; codes 6 and 7 are invalid. Oscillator enable bits are indexed 0 fast RC, 1 primary, 2 low-power crystal, 3 low-power RC. After reset, `clk_sel` equals `cfg_init_src`, the control word reads with current source (bits 14:12) and requested source (bits 10:8) equal to `cfg_init_src` and every other bit 0, and only the enable bit of the power-up source's oscillator is set.
- R2: While `cfg_sw_en` is low, the current source follows `cfg_init_src` within one cycle, writes to the requested-source field are ignored, and the start bit (bit 0) stays 0.
- R3: A start request whose requested source equals the current source clears bit 0 and leaves `clk_sel` unchanged.
- R4: A valid request clears the PLL-lock flag (bit 5) and the clock-fail flag (bit 3) before the target becomes ready. The fail flag is set by a pulse on `clk_fail_in`. The lock flag is set while a PLL source is in use, or is being waited for, and `pll_lock` is high.
- R5: The changeover does not happen while the target oscillator's ready input is low or, for a PLL target, while `pll_lock` is low. During the wait the target oscillator's enable (and `pll_en` for a PLL target) is high.
- R6: After the target is ready, at least 10 rising edges of the target oscillator's clock pass before `clk_sel` changes.
- R7: On completion, bit 0 clears, the current source takes the requested code, and the old oscillator's enable drops unless an R8 exception holds it.
- R8: The low-power RC enable stays high whenever `cfg_wdt_fscm` is high. The low-power crystal enable stays high whenever the keep bit (bit 1) is set.
- R9: A request from one PLL source to the other, or to an invalid code, is refused: bit 0 clears, `clk_sel` is unchanged and the sticky error flag (bit 7) sets. A low-byte write with bit 7 at 0 clears the error flag.
- R10: A high-byte write (bits 15:8) takes effect only in the cycle right after key writes 0x46 then 0x57 on consecutive cycles. A low-byte write (bits 7:0) takes effect only in the cycle right after key writes 0x78 then 0x9A on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sw_en | input | 1 | Run-time switching permitted |
| cfg_init_src | input | 3 | Power-up source code |
| cfg_wdt_fscm | input | 1 | Watchdog or fail monitor enabled (keeps low-power RC on) |
| key_wr | input | 1 | Key write strobe |
| key_data | input | 8 | Key value |
| reg_wr | input | 1 | Control word write strobe |
| reg_be | input | 2 | Byte enables (1 high byte, 0 low byte) |
| reg_wdata | input | 16 | Control word write data |
| rd_data | output | 16 | Control/status word image |
| clk_fail_in | input | 1 | Clock failure event pulse |
| osc_clk | input | 4 | Oscillator clocks, by oscillator index |
| osc_rdy | input | 4 | Oscillator ready (start-up timer expired) |
| pll_lock | input | 1 | PLL lock indication |
| osc_en | output | 4 | Oscillator enables |
| pll_en | output | 1 | PLL enable |
| clk_sel | output | 3 | Source code for the glitch-free mux |

## Verification
The assertions assume three things about the inputs. First, every oscillator clock keeps toggling while its ready input is high. Second, ready and lock inputs do not drop in the middle of a changeover. Third, `cfg_sw_en` and `cfg_init_src` change only while the block is idle. The stimulus keeps all four oscillator clocks free-running at unrelated periods. It moves ready and lock only to hold or release a pending request, never during the ten-edge count. It changes the configuration inputs only after the start bit has read back as zero.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  localparam int N_OSC = 4;

  localparam logic [2:0] SRC_FRC     = 3'd0;
  localparam logic [2:0] SRC_FRC_PLL = 3'd1;
  localparam logic [2:0] SRC_PRI     = 3'd2;
  localparam logic [2:0] SRC_PRI_PLL = 3'd3;
  localparam logic [2:0] SRC_LPOSC   = 3'd4;
  localparam logic [2:0] SRC_LPRC    = 3'd5;

  typedef enum logic [2:0] {ST_IDLE, ST_CHK, ST_WAIT, ST_CNT, ST_DROP} sw_state_t;

  function automatic logic src_pll(logic [2:0] s);
    return (s == SRC_FRC_PLL) || (s == SRC_PRI_PLL);
  endfunction

  function automatic logic src_valid(logic [2:0] s);
    return s <= SRC_LPRC;
  endfunction

  // oscillator index behind a source code
  function automatic logic [1:0] src_osc(logic [2:0] s);
    case (s)
      SRC_PRI, SRC_PRI_PLL: return 2'd1;
      SRC_LPOSC:            return 2'd2;
      SRC_LPRC:             return 2'd3;
      default:              return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    stg_q[0] <= d;
    for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/clksw_edge_cnt.sv
module clksw_edge_cnt #(
  parameter int EDGES  = 10,
  parameter int STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst_req,
  input  logic req,
  output logic done
);
  localparam int CW = $clog2(EDGES + 1);

  logic          rst_s, req_s;
  logic [CW-1:0] cnt_q;

  clksw_sync #(.WIDTH(2), .STAGES(STAGES)) u_sync (
    .clk(osc_clk), .d({rst_req, req}), .q({rst_s, req_s})
  );

  // counts target-clock edges once the request has crossed over
  always_ff @(posedge osc_clk) begin
    if (rst_s || !req_s) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      cnt_q <= cnt_q + CW'(1);
      if (cnt_q == CW'(EDGES - 1)) done <= 1'b1;
    end
  end

  AST_DONE_HELD: assert property (@(posedge osc_clk) disable iff (rst_s)
    (req_s && done) |=> done); // R6
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl import clksw_pkg::*; #(
  parameter int         SETTLE_EDGES = 10,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] KEY_HI_A     = 8'h46,
  parameter logic [7:0] KEY_HI_B     = 8'h57,
  parameter logic [7:0] KEY_LO_A     = 8'h78,
  parameter logic [7:0] KEY_LO_B     = 8'h9A
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_sw_en,
  input  logic [2:0]  cfg_init_src,
  input  logic        cfg_wdt_fscm,
  input  logic        key_wr,
  input  logic [7:0]  key_data,
  input  logic        reg_wr,
  input  logic [1:0]  reg_be,
  input  logic [15:0] reg_wdata,
  output logic [15:0] rd_data,
  input  logic        clk_fail_in,
  input  logic [3:0]  osc_clk,
  input  logic [3:0]  osc_rdy,
  input  logic        pll_lock,
  output logic [3:0]  osc_en,
  output logic        pll_en,
  output logic [2:0]  clk_sel
);
  sw_state_t        st_q;
  logic [2:0]       cur_q, nsrc_q, tgt_q;
  logic             go_q, err_q, lock_q, fail_q, keep_q;
  logic             hi_a_q, lo_a_q, unl_hi_q, unl_lo_q;
  logic [N_OSC-1:0] rdy_s, done_raw, done_s, cnt_req_q;
  logic             lock_s, wr_hi, wr_lo, tgt_ready, reject;
  logic             wdata_unused;

  assign wdata_unused = ^{reg_wdata[15:11], reg_wdata[6:2]};

  // ---------------- key unlock ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_a_q <= 1'b0; lo_a_q <= 1'b0; unl_hi_q <= 1'b0; unl_lo_q <= 1'b0;
    end else begin
      hi_a_q   <= key_wr && (key_data == KEY_HI_A);
      lo_a_q   <= key_wr && (key_data == KEY_LO_A);
      unl_hi_q <= key_wr && (key_data == KEY_HI_B) && hi_a_q;
      unl_lo_q <= key_wr && (key_data == KEY_LO_B) && lo_a_q;
    end
  end

  assign wr_hi = reg_wr && reg_be[1] && unl_hi_q && cfg_sw_en && !go_q;
  assign wr_lo = reg_wr && reg_be[0] && unl_lo_q;

  // ---------------- crossings ----------------
  clksw_sync #(.WIDTH(N_OSC + 1), .STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk(clk), .d({pll_lock, osc_rdy}), .q({lock_s, rdy_s})
  );
  clksw_sync #(.WIDTH(N_OSC), .STAGES(SYNC_STAGES)) u_done_sync (
    .clk(clk), .d(done_raw), .q(done_s)
  );

  for (genvar g = 0; g < N_OSC; g++) begin : g_cnt
    clksw_edge_cnt #(.EDGES(SETTLE_EDGES), .STAGES(SYNC_STAGES)) u_cnt (
      .osc_clk(osc_clk[g]), .rst_req(rst), .req(cnt_req_q[g]), .done(done_raw[g])
    );
  end

  assign tgt_ready = rdy_s[src_osc(tgt_q)] && (!src_pll(tgt_q) || lock_s);
  assign reject    = !src_valid(nsrc_q) ||
                     (src_pll(nsrc_q) && src_pll(cur_q) && (src_osc(nsrc_q) != src_osc(cur_q)));

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; cur_q <= cfg_init_src; nsrc_q <= cfg_init_src; tgt_q <= cfg_init_src;
      go_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0; fail_q <= 1'b0; keep_q <= 1'b0;
      cnt_req_q <= '0;
    end else begin
      if (clk_fail_in) fail_q <= 1'b1;
      if (wr_hi) nsrc_q <= reg_wdata[10:8];
      if (wr_lo) begin
        keep_q <= reg_wdata[1];
        if (!reg_wdata[7]) err_q <= 1'b0;
        if (cfg_sw_en && !go_q) go_q <= reg_wdata[0];
      end
      if (lock_s && ((st_q == ST_IDLE && src_pll(cur_q)) || (st_q == ST_WAIT && src_pll(tgt_q))))
        lock_q <= 1'b1;
      case (st_q)
        ST_IDLE: if (go_q) st_q <= ST_CHK;
        ST_CHK: begin
          if (nsrc_q == cur_q) begin
            go_q <= 1'b0; st_q <= ST_IDLE;
          end else if (reject) begin
            go_q <= 1'b0; err_q <= 1'b1; st_q <= ST_IDLE;
          end else begin
            tgt_q <= nsrc_q; lock_q <= 1'b0; fail_q <= 1'b0; st_q <= ST_WAIT;
          end
        end
        ST_WAIT: if (tgt_ready) begin
          cnt_req_q[src_osc(tgt_q)] <= 1'b1; st_q <= ST_CNT;
        end
        ST_CNT: if (done_s[src_osc(tgt_q)]) begin
          cur_q <= tgt_q; go_q <= 1'b0; cnt_req_q <= '0; st_q <= ST_DROP;
        end
        ST_DROP: if (done_s == '0) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
      if (!cfg_sw_en) begin
        cur_q <= cfg_init_src; tgt_q <= cfg_init_src; go_q <= 1'b0;
        cnt_req_q <= '0; st_q <= ST_DROP;
      end
    end
  end

  // ---------------- enables ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      osc_en <= (4'd1 << src_osc(cfg_init_src)) | {cfg_wdt_fscm, 3'b000};
      pll_en <= src_pll(cfg_init_src);
    end else begin
      osc_en <= (4'd1 << src_osc(cur_q)) | (4'd1 << src_osc(tgt_q)) |
                {cfg_wdt_fscm, keep_q, 2'b00};
      pll_en <= src_pll(cur_q) || src_pll(tgt_q);
    end
  end

  assign clk_sel = cur_q;
  assign rd_data = {1'b0, cur_q, 1'b0, nsrc_q, err_q, 1'b0, lock_q, 1'b0,
                    fail_q, 1'b0, keep_q, go_q};

  // ---------------- assertions ----------------
  AST_CFG_TRACK: assert property (@(posedge clk) disable iff (rst)
    !cfg_sw_en |=> (cur_q == $past(cfg_init_src)) && !go_q); // R2
  AST_REDUNDANT_DROP: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_en && st_q == ST_CHK && nsrc_q == cur_q) |=> !go_q && $stable(cur_q)); // R3
  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CHK && nsrc_q != cur_q && !reject) |=> !lock_q && !fail_q); // R4
  AST_NO_EARLY_COUNT: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_en && st_q == ST_WAIT && !tgt_ready) |=> cnt_req_q == '0); // R5
  AST_SWITCH_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_en && $past(cfg_sw_en) && !$stable(cur_q)) |-> $past(done_s[src_osc(tgt_q)])); // R6
  AST_PLL_PAIR_REFUSED: assert property (@(posedge clk) disable iff (rst)
    (cfg_sw_en && st_q == ST_CHK && nsrc_q != cur_q && reject) |=> err_q && !go_q && $stable(cur_q)); // R9
  AST_LPRC_KEPT: assert property (@(posedge clk) disable iff (rst)
    cfg_wdt_fscm |=> osc_en[3]); // R8
  AST_KEY_GATE: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_be[1] && unl_hi_q) |=> $stable(nsrc_q)); // R10
endmodule

// File: tb/sim_clksw_ctrl.sv
module sim_clksw_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_sw_en = 1'b1, cfg_wdt_fscm = 1'b0;
  logic [2:0]  cfg_init_src = 3'd0;
  logic        key_wr = 1'b0, reg_wr = 1'b0, clk_fail_in = 1'b0, pll_lock = 1'b1;
  logic [7:0]  key_data = 8'h00;
  logic [1:0]  reg_be = 2'b00;
  logic [15:0] reg_wdata = 16'h0000, rd_data;
  logic [3:0]  osc_clk = 4'h0, osc_rdy = 4'hF, osc_en;
  logic        pll_en;
  logic [2:0]  clk_sel;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #7  osc_clk[0] = ~osc_clk[0];
  always #11 osc_clk[1] = ~osc_clk[1];
  always #15 osc_clk[2] = ~osc_clk[2];
  always #17 osc_clk[3] = ~osc_clk[3];

  clksw_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_sw_en(cfg_sw_en), .cfg_init_src(cfg_init_src),
    .cfg_wdt_fscm(cfg_wdt_fscm), .key_wr(key_wr), .key_data(key_data), .reg_wr(reg_wr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .rd_data(rd_data), .clk_fail_in(clk_fail_in),
    .osc_clk(osc_clk), .osc_rdy(osc_rdy), .pll_lock(pll_lock), .osc_en(osc_en),
    .pll_en(pll_en), .clk_sel(clk_sel)
  );

  // {request code, expected current source, expected error flag}
  localparam logic [6:0] VEC [11] = '{
    {3'd2, 3'd2, 1'b0}, {3'd3, 3'd3, 1'b0}, {3'd1, 3'd3, 1'b1}, {3'd0, 3'd0, 1'b0},
    {3'd1, 3'd1, 1'b0}, {3'd3, 3'd1, 1'b1}, {3'd1, 3'd1, 1'b0}, {3'd5, 3'd5, 1'b0},
    {3'd4, 3'd4, 1'b0}, {3'd7, 3'd4, 1'b1}, {3'd0, 3'd0, 1'b0}
  };

  function automatic logic [3:0] exp_en(logic [2:0] s, logic wdt, logic keep);
    logic [3:0] m;
    case (s)
      3'd2, 3'd3: m = 4'b0010;
      3'd4:       m = 4'b0100;
      3'd5:       m = 4'b1000;
      default:    m = 4'b0001;
    endcase
    return m | {wdt, keep, 2'b00};
  endfunction

  task automatic tick(); @(negedge clk); endtask
  task automatic ticks(int n); for (int i = 0; i < n; i++) tick(); endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic key(logic [7:0] k);
    key_wr = 1'b1; key_data = k; tick(); key_wr = 1'b0;
  endtask

  task automatic wr(logic [1:0] be, logic [15:0] d);
    reg_wr = 1'b1; reg_be = be; reg_wdata = d; tick(); reg_wr = 1'b0; reg_be = 2'b00;
  endtask

  task automatic request(logic [2:0] code, logic keep);
    key(8'h46); key(8'h57); wr(2'b10, {5'd0, code, 8'h00});
    key(8'h78); key(8'h9A); wr(2'b01, {14'd0, keep, 1'b1});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && rd_data[0]; i++) tick();
    ticks(3);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    ticks(5); rst = 1'b0; tick();
    // R1 reset state
    chk("R1 clk_sel", clk_sel, 3'd0);
    chk("R1 rd_data", rd_data, 16'h0000);
    chk("R1 osc_en", osc_en, 4'b0001);
    chk("R1 pll_en", pll_en, 1'b0);

    // R10 locked writes ignored
    wr(2'b10, 16'h0200); tick();
    chk("R10 no key", rd_data[10:8], 3'd0);
    key(8'h57); key(8'h46); wr(2'b10, 16'h0200); tick();
    chk("R10 wrong order", rd_data[10:8], 3'd0);
    key(8'h46); tick(); key(8'h57); tick(); wr(2'b10, 16'h0200); tick();
    chk("R10 gap between keys", rd_data[10:8], 3'd0);
    key(8'h46); key(8'h57); wr(2'b01, 16'h0001); tick();
    chk("R10 high key on low byte", rd_data[0], 1'b0);

    // table walk: R3, R7, R9
    foreach (VEC[i]) begin
      request(VEC[i][6:4], 1'b0);
      wait_idle();
      chk("R7/R3/R9 clk_sel", clk_sel, VEC[i][3:1]);
      chk("R9 err flag", rd_data[7], VEC[i][0]);
      chk("R7 start clear", rd_data[0], 1'b0);
      chk("R7 old off", osc_en, exp_en(VEC[i][3:1], 1'b0, 1'b0));
    end

    // R5 + R6: crystal wait then edge count (low-power RC, 34 ns period)
    osc_rdy[3] = 1'b0;
    request(3'd5, 1'b0);
    ticks(60);
    chk("R5 held for ready", clk_sel, 3'd0);
    chk("R5 target enabled", osc_en[3], 1'b1);
    chk("R5 still pending", rd_data[0], 1'b1);
    osc_rdy[3] = 1'b1;
    n = 0;
    while (clk_sel != 3'd5 && n < 500) begin tick(); n++; end
    chk("R6 at least 10 target edges", n >= 34, 1'b1);
    chk("R6 completes", clk_sel, 3'd5);
    wait_idle();

    // R5 PLL lock wait
    pll_lock = 1'b0;
    request(3'd1, 1'b0);
    ticks(60);
    chk("R5 held for lock", clk_sel, 3'd5);
    chk("R5 pll enabled", pll_en, 1'b1);
    pll_lock = 1'b1;
    wait_idle();
    chk("R5 pll switch done", clk_sel, 3'd1);

    // R4 flag clearing
    ticks(4);
    chk("R4 lock set", rd_data[5], 1'b1);
    clk_fail_in = 1'b1; tick(); clk_fail_in = 1'b0; tick();
    chk("R4 fail set", rd_data[3], 1'b1);
    osc_rdy[2] = 1'b0;
    request(3'd4, 1'b0);
    ticks(10);
    chk("R4 lock cleared", rd_data[5], 1'b0);
    chk("R4 fail cleared", rd_data[3], 1'b0);
    osc_rdy[2] = 1'b1;
    wait_idle();
    chk("R4 switch done", clk_sel, 3'd4);

    // R8 keep exceptions
    cfg_wdt_fscm = 1'b1;
    request(3'd5, 1'b1);
    wait_idle();
    chk("R8 keep lp and lprc", osc_en, exp_en(3'd5, 1'b1, 1'b1));
    request(3'd0, 1'b0);
    wait_idle();
    chk("R8 wdt keeps lprc", osc_en, exp_en(3'd0, 1'b1, 1'b0));
    cfg_wdt_fscm = 1'b0; ticks(3);
    chk("R8 lprc released", osc_en, exp_en(3'd0, 1'b0, 1'b0));

    // R2 switching disabled
    cfg_sw_en = 1'b0; cfg_init_src = 3'd2; ticks(2);
    chk("R2 follows init", clk_sel, 3'd2);
    request(3'd3, 1'b0); tick();
    chk("R2 start forced low", rd_data[0], 1'b0);
    chk("R2 new field ignored", rd_data[10:8], 3'd0);
    chk("R2 no switch", clk_sel, 3'd2);
    cfg_init_src = 3'd5; ticks(2);
    chk("R2 follows init change", clk_sel, 3'd5);

    finish_run();
  end
endmodule